// File: doc/BRIEF.md
# Conditional Branch Next-PC Unit

This block holds the program counter of a 32-bit load/store processor and works out the address of the next instruction. Each cycle it is given two register operands, the value of the return-address register, a 16-bit immediate and a small code that names the kind of control transfer the decoder found. It compares the operands for the conditional kinds and picks one of four addresses: the sequential address, the branch target, the first operand, or the return address.

The chosen address is offered at once on `nextPc`. It is loaded into the program counter on a rising clock edge when `instrValid` is high. `pcSetByXfer` tells the surrounding pipeline that the instruction itself decided the PC. The sequential increment is then not applied on its own, even when a conditional branch falls through. Register reads, decode and instruction fetch are done by other blocks.

Top module: `nextpc_unit`

## Requirements
- R1: While `rstN` is low and after its release, `pcQ` equals the parameter `RESET_VEC` (default 32'h0000_1000) until the first valid instruction.
- R2: With `xferKind` = 0 (no transfer), `nextPc` = `pcQ` + 4 and `pcSetByXfer` is 0.
- R3: A taken conditional branch gives `nextPc` = `pcQ` + 4 + the sign-extended value of `imm16` with bits 1:0 forced to zero.
- R4: A conditional branch that is not taken gives `nextPc` = `pcQ` + 4.
- R5: `xferKind` = 1 is taken when `opA` >= `opB` as signed 32-bit numbers.
- R6: `xferKind` = 2 is taken when `opA` < `opB` as signed 32-bit numbers.
- R7: `xferKind` = 3 is taken when `opA` and `opB` differ in any bit.
- R8: `xferKind` = 4 is taken when `opA` >= `opB` unsigned, and `xferKind` = 5 when `opA` < `opB` unsigned.
- R9: `xferKind` = 6 gives `nextPc` = `opA`. `xferKind` = 7 gives `nextPc` = `retAddr`.
- R10: `pcSetByXfer` is 1 for every `xferKind` from 1 to 7, whether the branch is taken or not.
- R11: On a rising clock edge with `instrValid` high, `pcQ` takes the value of `nextPc`. Without `instrValid`, `pcQ` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | The current instruction commits on this edge |
| xferKind | input | 3 | Control-transfer code (encodings in R2, R5 to R9) |
| opA | input | 32 | First register operand |
| opB | input | 32 | Second register operand |
| retAddr | input | 32 | Return-address register value |
| imm16 | input | 16 | Branch offset immediate |
| pcQ | output | 32 | Current program counter |
| nextPc | output | 32 | Address of the next instruction |
| pcSetByXfer | output | 1 | The instruction has set the PC, so no default increment |

## Verification
The bound checker checks the following on every cycle:
- the sequential step, the hold of the PC when no instruction commits, and the register-indirect loads;
- the flag rule;
- the fall-through of a not-equal branch on equal operands.

The target arithmetic needs the bench's scenarios, which also choose the compare outcomes: negative and low-bit immediates, the most-negative operand against small values, equal operands, and wrap-around of the PC. These scenarios show the signed and unsigned compares giving different answers on the same operands, which no single-cycle property captures.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned IMMW   = 16;
  localparam int unsigned KINDW  = 3;
  localparam int unsigned ALIGNB = 2;

  typedef enum logic [KINDW-1:0] {
    XF_NONE  = 3'd0,
    XF_GE    = 3'd1,
    XF_LT    = 3'd2,
    XF_NE    = 3'd3,
    XF_GEU   = 3'd4,
    XF_LTU   = 3'd5,
    XF_JREG  = 3'd6,
    XF_RET   = 3'd7
  } xfer_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useTarget;
    logic useRegA;
    logic useRetReg;
    logic pcWritten;
  } pcSel_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic same;
    logic sLess;
    logic uLess;
  } cmpRes_t;
endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
#(
  parameter int unsigned KW = KINDW
) (
  input  logic [KW-1:0] xferKind,
  input  cmpRes_t       cmp,
  output pcSel_t        sel
);
  xfer_e kind;
  logic  taken;
  logic  isCond;

  assign kind = xfer_e'(xferKind);

  always_comb begin
    taken  = 1'b0;
    isCond = 1'b0;
    unique case (kind)
      XF_GE:   begin isCond = 1'b1; taken = ~cmp.sLess; end
      XF_LT:   begin isCond = 1'b1; taken =  cmp.sLess; end
      XF_NE:   begin isCond = 1'b1; taken = ~cmp.same;  end
      XF_GEU:  begin isCond = 1'b1; taken = ~cmp.uLess; end
      XF_LTU:  begin isCond = 1'b1; taken =  cmp.uLess; end
      default: begin isCond = 1'b0; taken = 1'b0;       end
    endcase
  end

  always_comb begin
    sel.useTarget = isCond & taken;
    sel.useRegA   = (kind == XF_JREG);
    sel.useRetReg = (kind == XF_RET);
    sel.pcWritten = (kind != XF_NONE);
  end
endmodule

// File: rtl/nextpc_dp.sv
module nextpc_dp
  import nextpc_pkg::*;
#(
  parameter int unsigned        W         = XLEN,
  parameter int unsigned        IW        = IMMW,
  parameter logic [XLEN-1:0]    RESET_VEC = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instrValid,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [W-1:0]  retAddr,
  input  logic [IW-1:0] imm16,
  input  pcSel_t        sel,
  output cmpRes_t       cmp,
  output logic [W-1:0]  pcQ,
  output logic [W-1:0]  nextPc
);
  localparam int unsigned EXTW = W - IW;
  localparam logic [W-1:0] STEP = W'(4);

  logic [W-1:0] seqPc;
  logic [W-1:0] offset;
  logic [W-1:0] target;
  logic [W-1:0] pcReg;

  assign seqPc  = pcReg + STEP;
  assign offset = {{EXTW{imm16[IW-1]}}, imm16[IW-1:ALIGNB], {ALIGNB{1'b0}}};
  assign target = seqPc + offset;

  assign cmp.same  = (opA == opB);
  assign cmp.sLess = ($signed(opA) < $signed(opB));
  assign cmp.uLess = (opA < opB);

  always_comb begin
    if (sel.useRegA)        nextPc = opA;
    else if (sel.useRetReg) nextPc = retAddr;
    else if (sel.useTarget) nextPc = target;
    else                    nextPc = seqPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pcReg <= RESET_VEC;
    else if (instrValid) pcReg <= nextPc;
  end

  assign pcQ = pcReg;
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [KINDW-1:0]  xferKind,
  input  logic [XLEN-1:0]   opA,
  input  logic [XLEN-1:0]   opB,
  input  logic [XLEN-1:0]   retAddr,
  input  logic [IMMW-1:0]   imm16,
  output logic [XLEN-1:0]   pcQ,
  output logic [XLEN-1:0]   nextPc,
  output logic              pcSetByXfer
);
  pcSel_t  sel;
  cmpRes_t cmp;

  nextpc_ctrl #(.KW(KINDW)) u_ctrl (
    .xferKind(xferKind),
    .cmp(cmp),
    .sel(sel)
  );

  nextpc_dp #(.W(XLEN), .IW(IMMW), .RESET_VEC(RESET_VEC)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .instrValid(instrValid),
    .opA(opA),
    .opB(opB),
    .retAddr(retAddr),
    .imm16(imm16),
    .sel(sel),
    .cmp(cmp),
    .pcQ(pcQ),
    .nextPc(nextPc)
  );

  assign pcSetByXfer = sel.pcWritten;
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [2:0]  xferKind,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] retAddr,
  input logic [15:0] imm16,
  input logic [31:0] pcQ,
  input logic [31:0] nextPc,
  input logic        pcSetByXfer
);
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && xferKind == 3'd0) |=> (pcQ == $past(pcQ) + 32'd4));

  p_flag_kind_r10: assert property (@(posedge clk) disable iff (!rstN)
    pcSetByXfer == (xferKind != 3'd0));

  p_ne_equal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferKind == 3'd3 && opA == opB) |-> (nextPc == pcQ + 32'd4));

  p_jreg_r9: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && xferKind == 3'd6) |=> (pcQ == $past(opA)));

  p_ret_r9: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && xferKind == 3'd7) |=> (pcQ == $past(retAddr)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> $stable(pcQ));
endmodule

bind nextpc_unit nextpc_unit_chk u_chk (.*);

// File: tb/nextpc_unit_tb.sv
`timescale 1ns/1ps
module nextpc_unit_tb;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [2:0]  xferKind = 3'd0;
  logic [31:0] opA = '0, opB = '0, retAddr = '0;
  logic [15:0] imm16 = '0;
  logic [31:0] pcQ, nextPc;
  logic        pcSetByXfer;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] pcModel;

  nextpc_unit #(.RESET_VEC(RV)) u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .xferKind(xferKind),
    .opA(opA), .opB(opB), .retAddr(retAddr), .imm16(imm16),
    .pcQ(pcQ), .nextPc(nextPc), .pcSetByXfer(pcSetByXfer)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit model_taken(input int k, input logic [31:0] a, input logic [31:0] b);
    int signed sa = a;
    int signed sb = b;
    longint unsigned ua = a;
    longint unsigned ub = b;
    case (k)
      1: return sa >= sb;
      2: return sa < sb;
      3: return a != b;
      4: return ua >= ub;
      5: return ua < ub;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_next(input int k, input logic [31:0] pc,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] r, input logic [15:0] im);
    int signed off = $signed({im[15:2], 2'b00});
    if (k == 6) return a;
    if (k == 7) return r;
    if (model_taken(k, a, b)) return pc + 32'd4 + off;
    return pc + 32'd4;
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0: return "R2";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4, 5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input bit v, input int k, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] r, input logic [15:0] im);
    logic [31:0] exp;
    string tg;
    @(negedge clk);
    check("R11", pcQ, pcModel);
    instrValid = v; xferKind = k[2:0]; opA = a; opB = b; retAddr = r; imm16 = im;
    #2;
    exp = model_next(k, pcModel, a, b, r, im);
    tg = tag_of(k);
    if (k >= 1 && k <= 5) tg = {tg, model_taken(k, a, b) ? " R3" : " R4"};
    check(tg, nextPc, exp);
    check("R10", {31'd0, pcSetByXfer}, {31'd0, (k != 0)});
    @(posedge clk);
    #1;
    if (v) pcModel = exp;
  endtask

  initial begin
    pcModel = RV;
    #25;
    check("R1", pcQ, RV);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", pcQ, RV);
    // R2 sequential
    step(1, 0, 0, 0, 0, 16'h1234);
    // R11 hold without valid
    step(0, 3, 1, 2, 0, 16'h0100);
    // R5 signed ge: equal taken, negative vs positive not taken
    step(1, 1, 32'h5, 32'h5, 0, 16'h0010);
    step(1, 1, 32'h8000_0000, 32'h1, 0, 16'h0010);
    // R6 signed lt: most negative < 1, taken with negative offset (R3)
    step(1, 2, 32'h8000_0000, 32'h1, 0, 16'hFFF0);
    step(1, 2, 32'h7, 32'h7, 0, 16'hFFF0);
    // R8 unsigned: same operands give opposite outcomes
    step(1, 5, 32'h8000_0000, 32'h1, 0, 16'h0040);
    step(1, 4, 32'h8000_0000, 32'h1, 0, 16'h0043);
    step(1, 4, 32'h2, 32'h3, 0, 16'h0040);
    // R7 not-equal: differ in one bit vs equal
    step(1, 3, 32'hA5A5_0001, 32'hA5A5_0000, 0, 16'h0007);
    step(1, 3, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 16'h0020);
    // R3 low bits cleared: imm FFFF -> -4, target equals current PC
    step(1, 3, 32'h1, 32'h0, 0, 16'hFFFF);
    step(1, 3, 32'h1, 32'h0, 0, 16'h0003);
    // R9 indirect
    step(1, 6, 32'hFFFF_FFFC, 0, 32'h0, 16'h0);
    step(1, 0, 0, 0, 0, 16'h0);
    step(1, 7, 32'h0, 0, 32'h0000_2000, 16'h0);
    step(0, 7, 32'h0, 0, 32'h0000_3000, 16'h0);
    step(1, 1, 32'h0, 32'h0, 0, 16'h8000);
    for (int i = 0; i < 300; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7),
           ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom,
           $urandom, $urandom, 16'($urandom));
    end
    @(negedge clk);
    check("R11", pcQ, pcModel);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule